// File: doc/BRIEF.md
# Floating-point condition compare unit

This unit compares two floating-point operands, either both single precision or both double precision, and decides which of four relations holds between them: less, equal, greater or unordered. An instruction supplies a 4-bit relation mask. The unit returns the mask bit that belongs to the relation it found, so one datapath serves every compare predicate. Decoding predicates into masks is done elsewhere.

A mode input chooses a quiet compare or a signaling compare. The two modes differ only in which NaN operands raise the invalid exception. The unit also returns a 5-bit exception vector in the same layout that the arithmetic units feed to the floating-point status logic. Only the invalid bit can ever be set. One cycle after a valid strobe, the condition bit and the exception vector appear in registers.

Top module: `fcmp_cond_unit`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `cmp_valid` high. `cond_out` and `exc_out` take their new values in that same cycle. While `cmp_valid` is low, both outputs hold their last values.
- R2: Exactly one relation is found. `cond_out` equals `rel_mask[k]`, where k is 0 for less, 1 for equal, 2 for greater and 3 for unordered.
- R3: Ordered operands compare by numeric value. This covers mixed signs, two negative values, infinities and denormals.
- R4: Positive zero and negative zero give the equal relation.
- R5: If either operand is a NaN (exponent all ones and fraction non-zero), the relation is unordered.
- R6: When `sig_mode` is 0 (quiet compare), invalid is raised only if an operand is a signaling NaN. A signaling NaN is a NaN whose fraction MSB is 0. A NaN whose fraction MSB is 1 is quiet and raises nothing.
- R7: When `sig_mode` is 1 (signaling compare), invalid is raised whenever either operand is any NaN.
- R8: When `is_dbl` is 0, only bits 31:0 of each operand are compared. Bits 63:32 have no effect on `cond_out` or `exc_out`.
- R9: `exc_out[4]` is the invalid flag. `exc_out[3:0]` (overflow, underflow, divide-by-zero, inexact) are always 0.
- R10: After reset, `res_valid`, `cond_out` and `exc_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request strobe |
| is_dbl | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| sig_mode | input | 1 | 1 = signaling compare, 0 = quiet compare |
| rel_mask | input | 4 | Relation select: bit0 less, bit1 equal, bit2 greater, bit3 unordered |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| res_valid | output | 1 | Registered result strobe |
| cond_out | output | 1 | Selected condition bit |
| exc_out | output | 5 | Exception vector, bit 4 = invalid |

## Verification
The hardest cases to reach are those where the upper operand bits in single-precision mode would change the answer if they were wrongly used. The stimulus places a signaling-NaN double pattern, or a value with a different sign, in bits 63:32. It keeps equal single-precision values in the low halves, so any leak of the upper bits into the compare shows up as a wrong relation or a spurious invalid flag. A second hard case is telling quiet NaNs from signaling NaNs across both modes. The same NaN pairs are therefore issued back to back, with `sig_mode` toggled and with the mask set to the unordered bit only, so both the condition and the invalid flag are checked.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    localparam int EXC_W   = 5;
    localparam int EXC_INV = 4;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_nan;
        logic is_snan;
    } fpclass_t;

    typedef struct packed {
        logic             vld;
        logic             cond;
        logic [EXC_W-1:0] exc;
    } out_st_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52,
    localparam int VAL_W = EXP_W + MAN_W + 1,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [VAL_W-1:0] val,
    output fpclass_t         cls,
    output logic [MAG_W-1:0] mag
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;
    logic             exp_ones;
    logic             frac_nz;

    always_comb begin
        expo        = val[VAL_W-2 -: EXP_W];
        frac        = val[MAN_W-1:0];
        exp_ones    = &expo;
        frac_nz     = |frac;
        mag         = val[MAG_W-1:0];
        cls.sign    = val[VAL_W-1];
        cls.is_zero = ~|mag;
        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~frac[MAN_W-1];
    end
endmodule

// File: rtl/fcmp_relation.sv
module fcmp_relation
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  fpclass_t         cls_a,
    input  fpclass_t         cls_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output rel_e             rel
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
        if (cls_a.is_nan || cls_b.is_nan) begin
            rel = REL_UN;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            rel = REL_EQ;
        end else if (cls_a.sign != cls_b.sign) begin
            rel = cls_a.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel = REL_EQ;
        end else if (mag_lt ^ cls_a.sign) begin
            rel = REL_LT;
        end else begin
            rel = REL_GT;
        end
    end
endmodule

// File: rtl/fcmp_cond_select.sv
module fcmp_cond_select
    import fcmp_pkg::*;
(
    input  rel_e             rel,
    input  logic [3:0]       rel_mask,
    input  logic             sig_mode,
    input  logic             any_nan,
    input  logic             any_snan,
    output logic             cond,
    output logic [EXC_W-1:0] exc
);
    always_comb begin
        cond         = rel_mask[rel];
        exc          = '0;
        exc[EXC_INV] = sig_mode ? any_nan : any_snan;
    end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52,
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmp_valid,
    input  logic        is_dbl,
    input  logic        sig_mode,
    input  logic [3:0]  rel_mask,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    output logic        res_valid,
    output logic        cond_out,
    output logic [4:0]  exc_out
);
    localparam int DP_W   = DP_EXP + DP_MAN + 1;
    localparam int SP_W   = SP_EXP + SP_MAN + 1;
    localparam int DP_MAG = DP_W - 1;
    localparam int SP_MAG = SP_W - 1;
    localparam int N_OPS  = 2;

    logic [DP_W-1:0]   opnd    [N_OPS];
    fpclass_t          cls_sel [N_OPS];
    logic [DP_MAG-1:0] mag_sel [N_OPS];

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_opnd
        fpclass_t          cls_dp;
        fpclass_t          cls_sp;
        logic [DP_MAG-1:0] mag_dp;
        logic [SP_MAG-1:0] mag_sp;

        fcmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_cls_dp (
            .val (opnd[i]),
            .cls (cls_dp),
            .mag (mag_dp)
        );

        fcmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_cls_sp (
            .val (opnd[i][SP_W-1:0]),
            .cls (cls_sp),
            .mag (mag_sp)
        );

        always_comb begin
            if (is_dbl) begin
                cls_sel[i] = cls_dp;
                mag_sel[i] = mag_dp;
            end else begin
                cls_sel[i] = cls_sp;
                mag_sel[i] = {{(DP_MAG-SP_MAG){1'b0}}, mag_sp};
            end
        end
    end

    rel_e             rel_w;
    logic             cond_w;
    logic [EXC_W-1:0] exc_w;
    logic             any_nan_w;
    logic             any_snan_w;

    assign any_nan_w  = cls_sel[0].is_nan  | cls_sel[1].is_nan;
    assign any_snan_w = cls_sel[0].is_snan | cls_sel[1].is_snan;

    fcmp_relation #(.MAG_W(DP_MAG)) u_rel (
        .cls_a (cls_sel[0]),
        .cls_b (cls_sel[1]),
        .mag_a (mag_sel[0]),
        .mag_b (mag_sel[1]),
        .rel   (rel_w)
    );

    fcmp_cond_select u_sel (
        .rel      (rel_w),
        .rel_mask (rel_mask),
        .sig_mode (sig_mode),
        .any_nan  (any_nan_w),
        .any_snan (any_snan_w),
        .cond     (cond_w),
        .exc      (exc_w)
    );

    out_st_t st_d;
    out_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = cmp_valid;
        if (cmp_valid) begin
            st_d.cond = cond_w;
            st_d.exc  = exc_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.vld;
    assign cond_out  = st_q.cond;
    assign exc_out   = st_q.exc;
endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_valid,
    input logic        is_dbl,
    input logic        sig_mode,
    input logic [3:0]  rel_mask,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic        res_valid,
    input logic        cond_out,
    input logic [4:0]  exc_out
);
    logic a_dnan;
    logic b_dnan;
    logic same_num;
    assign a_dnan   = (&op_a[62:52]) && (|op_a[51:0]);
    assign b_dnan   = (&op_b[62:52]) && (|op_b[51:0]);
    assign same_num = is_dbl && (op_a == op_b) && !a_dnan;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> res_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !res_valid && $stable(cond_out) && $stable(exc_out));

    // R2
    all_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && rel_mask == 4'hF) |=> cond_out);

    // R2
    none_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && rel_mask == 4'h0) |=> !cond_out);

    // R3
    self_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && same_num) |=> cond_out == $past(rel_mask[1]));

    // R7
    sig_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && is_dbl && sig_mode && (a_dnan || b_dnan)) |=> exc_out[4]);

    // R9
    only_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> exc_out[3:0] == 4'b0);
endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .is_dbl    (is_dbl),
    .sig_mode  (sig_mode),
    .rel_mask  (rel_mask),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_valid (res_valid),
    .cond_out  (cond_out),
    .exc_out   (exc_out)
);

// File: tb/sim_fcmp_cond_unit.sv
module sim_fcmp_cond_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        is_dbl = 1'b0;
    logic        sig_mode = 1'b0;
    logic [3:0]  rel_mask = 4'h0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        res_valid;
    logic        cond_out;
    logic [4:0]  exc_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic       cond;
        logic [4:0] exc;
        string      req;
    } exp_t;
    exp_t sb[$];
    logic       last_cond = 1'b0;
    logic [4:0] last_exc  = 5'd0;

    always #5 clk = ~clk;

    fcmp_cond_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .is_dbl(is_dbl),
        .sig_mode(sig_mode), .rel_mask(rel_mask), .op_a(op_a), .op_b(op_b),
        .res_valid(res_valid), .cond_out(cond_out), .exc_out(exc_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // rel: 0 less, 1 equal, 2 greater, 3 unordered
    task automatic issue(input logic dbl, input logic sig, input logic [3:0] m,
                         input logic [63:0] a, input logic [63:0] b,
                         input int rel, input logic inv, input string req);
        exp_t e;
        @(negedge clk);
        cmp_valid = 1'b1;
        is_dbl    = dbl;
        sig_mode  = sig;
        rel_mask  = m;
        op_a      = a;
        op_b      = b;
        e.cond    = m[rel];
        e.exc     = {inv, 4'b0000};
        e.req     = req;
        last_cond = e.cond;
        last_exc  = e.exc;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin : monitor
        exp_t e;
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected result", 8'd1, 8'd0);
            end else begin
                e = sb.pop_front();
                check({e.req, " cond"}, {7'd0, cond_out}, {7'd0, e.cond});
                check({e.req, " exc"},  {3'd0, exc_out},  {3'd0, e.exc});
            end
        end
    end

    localparam logic [63:0] S1   = 64'h3F80_0000, S2 = 64'h4000_0000;
    localparam logic [63:0] SM1  = 64'hBF80_0000, SZ = 64'h0, SNZ = 64'h8000_0000;
    localparam logic [63:0] SINF = 64'h7F80_0000, SNINF = 64'hFF80_0000;
    localparam logic [63:0] SQN  = 64'h7FC0_0000, SSN = 64'h7F80_0001, SDEN = 64'h1;
    localparam logic [63:0] D1   = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DM2  = 64'hC000_0000_0000_0000, DNZ = 64'h8000_0000_0000_0000;
    localparam logic [63:0] DQN  = 64'h7FF8_0000_0000_0000, DSN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] DINF = 64'h7FF0_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", {7'd0, res_valid}, 8'd0);
        check("R10 cond",  {7'd0, cond_out},  8'd0);
        check("R10 exc",   {3'd0, exc_out},   8'd0);
        rst_n = 1'b1;

        // R2 each relation selected through its own mask bit
        issue(0, 0, 4'b0001, S1, S2, 0, 0, "R2 lt");
        issue(0, 0, 4'b1110, S1, S2, 0, 0, "R2 lt masked");
        issue(0, 0, 4'b0010, S2, S2, 1, 0, "R2 eq");
        issue(0, 0, 4'b0100, S2, S1, 2, 0, "R2 gt");
        issue(0, 0, 4'b1000, SQN, S1, 3, 0, "R2 un");
        // R3 ordered values
        issue(0, 0, 4'b0001, SM1, S1, 0, 0, "R3 mixed sign");
        issue(0, 0, 4'b0100, SM1, 64'hC000_0000, 2, 0, "R3 both neg");
        issue(0, 0, 4'b0001, SNINF, SM1, 0, 0, "R3 -inf");
        issue(0, 0, 4'b0100, SINF, S2, 2, 0, "R3 +inf");
        issue(0, 0, 4'b0100, SDEN, SZ, 2, 0, "R3 denormal");
        issue(1, 0, 4'b0001, DM2, D1, 0, 0, "R3 dbl");
        issue(1, 0, 4'b0100, DINF, D2, 2, 0, "R3 dbl inf");
        // R4 signed zeros
        issue(0, 0, 4'b0010, SNZ, SZ, 1, 0, "R4 sp");
        issue(1, 1, 4'b0010, 64'h0, DNZ, 1, 0, "R4 dp");
        // R5 R6 R7 NaN handling
        issue(0, 0, 4'b1000, S1, SQN, 3, 0, "R6 quiet qnan");
        issue(0, 0, 4'b1000, S1, SSN, 3, 1, "R6 quiet snan");
        issue(0, 1, 4'b1000, S1, SQN, 3, 1, "R7 sig qnan");
        issue(0, 1, 4'b0111, SSN, S1, 3, 1, "R7 sig snan");
        issue(1, 0, 4'b0111, DQN, D1, 3, 0, "R5 dbl qnan");
        issue(1, 0, 4'b1000, D1, DSN, 3, 1, "R6 dbl snan");
        issue(1, 1, 4'b1000, DQN, DQN, 3, 1, "R7 dbl qnan");
        issue(1, 1, 4'b0010, D1, D1, 1, 0, "R7 sig no nan");
        // R8 upper halves ignored in single precision
        issue(0, 1, 4'b0010, {32'h7FF0_0001, 32'h3F80_0000}, S1, 1, 0, "R8 upper nan");
        issue(0, 0, 4'b0001, {32'h8000_0000, 32'h3F80_0000}, S2, 0, 0, "R8 upper sign");
        // R9 invalid only on bit 4, even with all mask bits
        issue(0, 1, 4'b1111, SSN, SSN, 3, 1, "R9 exc layout");

        @(negedge clk);
        cmp_valid = 1'b0;
        op_a = D2;
        op_b = DSN;
        rel_mask = 4'b0000;
        repeat (3) @(negedge clk);
        // R1 outputs held while idle
        check("R1 idle valid", {7'd0, res_valid}, 8'd0);
        check("R1 hold cond",  {7'd0, cond_out},  {7'd0, last_cond});
        check("R1 hold exc",   {3'd0, exc_out},   {3'd0, last_exc});
        check("R1 all consumed", 8'(sb.size()), 8'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule